// File: doc/BRIEF.md
# Task-Event UART Register Block

This block is the software-facing half of a UART. A processor drives it over a simple 32-bit register bus. It writes trigger registers ("tasks") to start or stop the receiver and the transmitter. It sees what has happened through sticky flag registers ("events"), which software clears by writing zero. A single level interrupt is raised whenever an event is set and its enable bit is on. The enable register can be written whole, or changed through a set alias or a clear alias.

On the line side, a byte-wide receive port and a byte-wide transmit port, each with valid/ready, stand in for the serializer. Received bytes go into a small circular buffer that software drains by reading the receive data register. One transmit byte at a time is held until the line side accepts it. A break input records an error. The baud and pin-select registers are plain storage with fixed reset values. No write other than the one to the enable register has any effect while the peripheral is disabled.

Top module: `tev_uart_regs`

## Requirements
- R1: After reset the four pin-select registers (0x310, 0x314, 0x318, 0x31C) read 0xFFFFFFFF and the baud register (0x30C) reads 0x04000000. The enable (0x300), interrupt-enable, event and error-source registers read 0. `irq`, `txb_valid` and `rxb_ready` are 0.
- R2: `irq` is high exactly when some event is 1 and its enable bit is 1. The event bit map is: bit0 receive-ready (event at 0x100), bit1 transmit-ready (0x104), bit2 error (0x108), bit3 receive-timeout (0x10C).
- R3: A write to 0x200 replaces the interrupt-enable value. A write to 0x204 ORs the data into it. A write to 0x208 clears the bits that are 1 in the data. Reads of 0x200 return the value.
- R4: While the enable register holds 0, every bus write except one to 0x300 is ignored. Any nonzero value enables the peripheral.
- R5: A write to the transmit data register (0x308) is accepted only when the transmitter is started (task 0x008) and no byte is pending. The accepted byte is shown on `txb_data` with `txb_valid` high until `txb_ready`. That handshake clears the pending flag and sets the transmit-ready event.
- R6: `rxb_ready` is high only when the receiver is started (task 0x000) and fewer than 6 bytes are buffered. A byte offered while it is low is dropped. A stored byte sets the receive-ready event.
- R7: A read of 0x304 returns the oldest buffered byte. If the receiver is started and the buffer is not empty, the read removes that byte. If bytes remain after the removal, the receive-ready event is set again.
- R8: Writing a value with bit0 = 1 to the stop-receiver task (0x004) stops the receiver and sets the receive-timeout event. The stop-transmitter task (0x00C) only stops the transmitter. Tasks act only when write data bit0 is 1.
- R9: Event registers take write data bit0 as their new value. The error-source register (0x280) is write-one-to-clear.
- R10: A pulse on `line_break` sets error-source bits 0 and 1 and the error event.
- R11: Task offsets and unmapped offsets read as 0.
- R12: When a byte is stored and one is removed in the same cycle, the buffer keeps its count and its first-in first-out order. The push is judged against the fullness seen before the pop. A hardware event set beats a software write of 0 to the same event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives read side effects) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| rxb_valid | input | 1 | Received byte offered |
| rxb_data | input | 8 | Received byte |
| rxb_ready | output | 1 | Block can store a received byte |
| txb_valid | output | 1 | Transmit byte pending |
| txb_data | output | 8 | Pending transmit byte |
| txb_ready | input | 1 | Line side takes the pending byte |
| line_break | input | 1 | Break condition seen on the line |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of actions can land in the same cycle. A byte can arrive while software reads the receive data register. A hardware event can be set while software writes zero to that same event. The bench triggers both on purpose by driving `rxb_valid` in the cycle that carries the bus read or write. It then judges the result from outside the block: it drains the buffer to confirm byte order and count, and it reads the event back. It also pushes into a full buffer in the same cycle as a pop, and expects the new byte to be dropped.

// File: rtl/tev_uart_pkg.sv
package tev_uart_pkg;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int RX_DEPTH = 6;
    localparam int NUM_EVT  = 4;
    localparam int NUM_PIN  = 4;
    localparam int ERR_W    = 4;

    localparam logic [DATA_W-1:0] PIN_RST  = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] BAUD_RST = 32'h0400_0000;

    localparam logic [ADDR_W-1:0] OFS_RX_START = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_RX_STOP  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_TX_START = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_TX_STOP  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_EVT_BASE = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_IEN      = 12'h200;
    localparam logic [ADDR_W-1:0] OFS_IEN_SET  = 12'h204;
    localparam logic [ADDR_W-1:0] OFS_IEN_CLR  = 12'h208;
    localparam logic [ADDR_W-1:0] OFS_ERRSRC   = 12'h280;
    localparam logic [ADDR_W-1:0] OFS_ENABLE   = 12'h300;
    localparam logic [ADDR_W-1:0] OFS_RXD      = 12'h304;
    localparam logic [ADDR_W-1:0] OFS_TXD      = 12'h308;
    localparam logic [ADDR_W-1:0] OFS_BAUD     = 12'h30C;
    localparam logic [ADDR_W-1:0] OFS_PIN_BASE = 12'h310;

    localparam int EV_RXRDY = 0;
    localparam int EV_TXRDY = 1;
    localparam int EV_ERR   = 2;
    localparam int EV_RXTMO = 3;
endpackage

// File: rtl/tev_uart_rxbuf.sv
module tev_uart_rxbuf #(
    parameter int DEPTH  = 6,
    parameter int BYTE_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop,
    output logic [BYTE_W-1:0] head_data,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [PTR_W:0]   DEPTH_P = (PTR_W + 1)'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [PTR_W-1:0]             head;
        logic [CNT_W-1:0]             count;
    } buf_t;

    buf_t s_d, s_q;
    logic [PTR_W:0]   tail_sum;
    logic [PTR_W-1:0] tail;

    always_comb begin
        s_d      = s_q;
        tail_sum = {1'b0, s_q.head} + (PTR_W + 1)'(s_q.count);
        if (tail_sum >= DEPTH_P) begin
            tail_sum = tail_sum - DEPTH_P;
        end
        tail = tail_sum[PTR_W-1:0];
        if (push) begin
            s_d.mem[tail] = push_data;
        end
        if (pop) begin
            s_d.head = (s_q.head == LAST_P) ? '0 : s_q.head + 1'b1;
        end
        case ({push, pop})
            2'b10:   s_d.count = s_q.count + 1'b1;
            2'b01:   s_d.count = s_q.count - 1'b1;
            default: s_d.count = s_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_data = s_q.mem[s_q.head];
    assign count     = s_q.count;
    assign full      = (s_q.count == DEPTH_C);
    assign empty     = (s_q.count == '0);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= DEPTH_C);
    p_push_not_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_pop_not_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_pushpop_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> (s_q.count == $past(s_q.count)));
endmodule

// File: rtl/tev_uart_txhold.sv
module tev_uart_txhold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              done
);
    typedef struct packed {
        logic              pending;
        logic [BYTE_W-1:0] data;
    } hold_t;

    hold_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.pending && tx_ready) begin
            s_d.pending = 1'b0;
        end
        if (load) begin
            s_d.pending = 1'b1;
            s_d.data    = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_valid = s_q.pending;
    assign tx_data  = s_q.data;
    assign done     = s_q.pending && tx_ready;

    p_load_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !tx_valid);
    p_hold_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/tev_uart_irq.sv
module tev_uart_irq #(
    parameter int NUM_EVT = 4
) (
    input  logic [NUM_EVT-1:0] evt,
    input  logic [NUM_EVT-1:0] ien,
    output logic               irq
);
    logic [NUM_EVT-1:0] hit;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_term
        assign hit[i] = evt[i] & ien[i];
    end

    assign irq = |hit;
endmodule

// File: rtl/tev_uart_regs.sv
module tev_uart_regs
    import tev_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rxb_valid,
    input  logic [7:0]        rxb_data,
    output logic              rxb_ready,
    output logic              txb_valid,
    output logic [7:0]        txb_data,
    input  logic              txb_ready,
    input  logic              line_break,
    output logic              irq
);
    localparam int CNT_W = $clog2(RX_DEPTH + 1);

    typedef struct packed {
        logic [DATA_W-1:0]              enable;
        logic [DATA_W-1:0]              baud;
        logic [NUM_PIN-1:0][DATA_W-1:0] pinsel;
        logic [NUM_EVT-1:0]             ien;
        logic [NUM_EVT-1:0]             evt;
        logic [ERR_W-1:0]               errsrc;
        logic                           rx_started;
        logic                           tx_started;
    } regs_t;

    regs_t s_d, s_q;

    logic [ADDR_W-1:0] off;
    logic              enabled, wr_ok;
    logic              rx_start, rx_stop, tx_start, tx_stop;
    logic              txd_load, rx_push, rx_pop;
    logic              in_evt, in_pin;
    logic [1:0]        sub_idx;
    logic [BYTE_W-1:0] rx_head;
    logic [CNT_W-1:0]  rx_count;
    logic              rx_full, rx_empty, tx_done;

    assign off       = bus_addr & ~ADDR_W'(3);
    assign enabled   = (s_q.enable != '0);
    assign wr_ok     = bus_wr && (enabled || off == OFS_ENABLE);
    assign rx_start  = wr_ok && (off == OFS_RX_START) && bus_wdata[0];
    assign rx_stop   = wr_ok && (off == OFS_RX_STOP) && bus_wdata[0];
    assign tx_start  = wr_ok && (off == OFS_TX_START) && bus_wdata[0];
    assign tx_stop   = wr_ok && (off == OFS_TX_STOP) && bus_wdata[0];
    assign txd_load  = wr_ok && (off == OFS_TXD) && s_q.tx_started && !txb_valid;
    assign rxb_ready = s_q.rx_started && !rx_full;
    assign rx_push   = rxb_valid && rxb_ready;
    assign rx_pop    = bus_rd && (off == OFS_RXD) && s_q.rx_started && !rx_empty;
    assign in_evt    = (off[ADDR_W-1:4] == OFS_EVT_BASE[ADDR_W-1:4]);
    assign in_pin    = (off[ADDR_W-1:4] == OFS_PIN_BASE[ADDR_W-1:4]);
    assign sub_idx   = off[3:2];

    tev_uart_rxbuf #(.DEPTH(RX_DEPTH), .BYTE_W(BYTE_W)) rxbuf_i (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rxb_data), .pop(rx_pop),
        .head_data(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    tev_uart_txhold #(.BYTE_W(BYTE_W)) txhold_i (
        .clk(clk), .rst_n(rst_n),
        .load(txd_load), .load_data(bus_wdata[BYTE_W-1:0]), .tx_ready(txb_ready),
        .tx_valid(txb_valid), .tx_data(txb_data), .done(tx_done)
    );

    tev_uart_irq #(.NUM_EVT(NUM_EVT)) irq_i (
        .evt(s_q.evt), .ien(s_q.ien), .irq(irq)
    );

    // Software writes first, hardware event sets last so they win (R12).
    always_comb begin
        s_d = s_q;
        if (wr_ok) begin
            case (off)
                OFS_IEN:     s_d.ien    = bus_wdata[NUM_EVT-1:0];
                OFS_IEN_SET: s_d.ien    = s_q.ien | bus_wdata[NUM_EVT-1:0];
                OFS_IEN_CLR: s_d.ien    = s_q.ien & ~bus_wdata[NUM_EVT-1:0];
                OFS_ERRSRC:  s_d.errsrc = s_q.errsrc & ~bus_wdata[ERR_W-1:0];
                OFS_ENABLE:  s_d.enable = bus_wdata;
                OFS_BAUD:    s_d.baud   = bus_wdata;
                default:     ;
            endcase
            if (in_evt) begin
                s_d.evt[sub_idx] = bus_wdata[0];
            end
            if (in_pin) begin
                s_d.pinsel[sub_idx] = bus_wdata;
            end
        end
        if (rx_start) s_d.rx_started = 1'b1;
        if (tx_start) s_d.tx_started = 1'b1;
        if (tx_stop)  s_d.tx_started = 1'b0;
        if (rx_stop) begin
            s_d.rx_started      = 1'b0;
            s_d.evt[EV_RXTMO]   = 1'b1;
        end
        if (rx_push || (rx_pop && rx_count > CNT_W'(1))) begin
            s_d.evt[EV_RXRDY] = 1'b1;
        end
        if (tx_done) begin
            s_d.evt[EV_TXRDY] = 1'b1;
        end
        if (line_break) begin
            s_d.errsrc      = s_d.errsrc | ERR_W'(3);
            s_d.evt[EV_ERR] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.baud   <= BAUD_RST;
            s_q.pinsel <= {NUM_PIN{PIN_RST}};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (off)
            OFS_IEN:    bus_rdata = DATA_W'(s_q.ien);
            OFS_ERRSRC: bus_rdata = DATA_W'(s_q.errsrc);
            OFS_ENABLE: bus_rdata = s_q.enable;
            OFS_RXD:    bus_rdata = DATA_W'(rx_head);
            OFS_BAUD:   bus_rdata = s_q.baud;
            default:    ;
        endcase
        if (in_evt) bus_rdata = DATA_W'(s_q.evt[sub_idx]);
        if (in_pin) bus_rdata = s_q.pinsel[sub_idx];
    end

    p_irq_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ien == '0) |-> !irq);
    p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !enabled && off != OFS_ENABLE) |=> $stable(s_q.ien));
    p_stop_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stop |=> (!rxb_ready && s_q.evt[EV_RXTMO]));
    p_stop_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop |=> (!s_q.tx_started && $stable(s_q.rx_started)));
    p_break_r10: assert property (@(posedge clk) disable iff (!rst_n)
        line_break |=> (s_q.evt[EV_ERR] && s_q.errsrc[1:0] == 2'b11));
    p_push_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> s_q.evt[EV_RXRDY]);
endmodule

// File: tb/tev_uart_regs_tb_top.sv
`timescale 1ns/1ps
module tev_uart_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        rxb_valid = 1'b0, rxb_ready;
    logic [7:0]  rxb_data = '0;
    logic        txb_valid, txb_ready = 1'b0;
    logic [7:0]  txb_data;
    logic        line_break = 1'b0, irq;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tev_uart_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxb_valid(rxb_valid),
        .rxb_data(rxb_data), .rxb_ready(rxb_ready), .txb_valid(txb_valid),
        .txb_data(txb_data), .txb_ready(txb_ready), .line_break(line_break), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #0.5 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rxb_valid = 1'b1; rxb_data = b;
        @(negedge clk);
        rxb_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        for (int i = 0; i < 4; i++) rd_chk("R1 pinsel", 12'h310 + 12'(4 * i), 32'hFFFF_FFFF);
        rd_chk("R1 baud", 12'h30C, 32'h0400_0000);
        rd_chk("R1 enable", 12'h300, 0);
        rd_chk("R1 ien", 12'h200, 0);
        rd_chk("R1 errsrc", 12'h280, 0);
        for (int i = 0; i < 4; i++) rd_chk("R1 event", 12'h100 + 12'(4 * i), 0);
        check("R1 outputs", {29'b0, irq, txb_valid, rxb_ready}, 0);

        // R4 writes ignored while disabled
        wr(12'h200, 32'hF);
        rd_chk("R4 ien ignored", 12'h200, 0);
        wr(12'h000, 1);
        check("R4 rx start ignored", {31'b0, rxb_ready}, 0);
        wr(12'h30C, 32'h1234);
        rd_chk("R4 baud ignored", 12'h30C, 32'h0400_0000);
        wr(12'h300, 4);
        rd_chk("R4 enable written", 12'h300, 4);

        // R2 irq sweep over all event/enable pairs
        for (int ev = 0; ev < 16; ev++) begin
            for (int i = 0; i < 4; i++) wr(12'h100 + 12'(4 * i), 32'(ev >> i) & 1);
            for (int ie = 0; ie < 16; ie++) begin
                wr(12'h200, 32'(ie));
                check("R2 irq", {31'b0, irq}, {31'b0, (ev & ie) != 0});
            end
        end
        for (int i = 0; i < 4; i++) wr(12'h100 + 12'(4 * i), 0);

        // R3 set / clear aliases
        for (int a = 0; a < 16; a++) begin
            for (int m = 0; m < 16; m++) begin
                wr(12'h200, 32'(a));
                wr(12'h204, 32'(m));
                rd_chk("R3 set", 12'h200, 32'(a | m));
                wr(12'h208, 32'(m));
                rd_chk("R3 clear", 12'h200, 32'((a | m) & ~m & 15));
            end
        end
        wr(12'h200, 0);

        // R11 tasks and unmapped read zero
        rd_chk("R11 task", 12'h000, 0);
        rd_chk("R11 task", 12'h00C, 0);
        rd_chk("R11 unmapped", 12'h3FC, 0);
        rd_chk("R11 unmapped", 12'h104 + 12'h010, 0);

        // R6/R7 receive sweep over fill levels 0..8
        wr(12'h000, 1);
        for (int n = 0; n <= 8; n++) begin
            int kept;
            kept = (n < 6) ? n : 6;
            wr(12'h100, 0);
            for (int i = 0; i < n; i++) push(8'(n * 16 + i));
            check("R6 ready vs fill", {31'b0, rxb_ready}, {31'b0, n < 6});
            rd_chk("R6 rx event", 12'h100, 32'(n > 0));
            for (int i = 0; i < kept; i++) begin
                wr(12'h100, 0);
                rd_chk("R7 rx byte", 12'h304, 32'(n * 16 + i));
                rd_chk("R7 rx event again", 12'h100, 32'(i < kept - 1));
            end
            check("R6 ready after drain", {31'b0, rxb_ready}, 1);
        end

        // R12 push and pop in the same cycle
        wr(12'h100, 0);
        push(8'h11); push(8'h22);
        @(negedge clk);
        bus_addr = 12'h304; bus_rd = 1'b1; rxb_valid = 1'b1; rxb_data = 8'h33;
        #0.5 check("R12 pop head", bus_rdata, 32'h11);
        @(negedge clk);
        bus_rd = 1'b0; rxb_valid = 1'b0;
        rd_chk("R12 order", 12'h304, 32'h22);
        wr(12'h100, 0);
        rd_chk("R12 order", 12'h304, 32'h33);
        rd_chk("R12 count", 12'h100, 0);
        // full buffer: push in the pop cycle is dropped
        for (int i = 0; i < 6; i++) push(8'h40 + 8'(i));
        @(negedge clk);
        bus_addr = 12'h304; bus_rd = 1'b1; rxb_valid = 1'b1; rxb_data = 8'h77;
        #0.5 check("R12 full ready", {31'b0, rxb_ready}, 0);
        @(negedge clk);
        bus_rd = 1'b0; rxb_valid = 1'b0;
        for (int i = 1; i < 6; i++) rd_chk("R12 full drain", 12'h304, 32'h40 + 32'(i));
        wr(12'h100, 0);
        rd_chk("R12 full dropped", 12'h100, 0);
        // hardware set beats software clear
        @(negedge clk);
        bus_addr = 12'h100; bus_wdata = 0; bus_wr = 1'b1; rxb_valid = 1'b1; rxb_data = 8'h5A;
        @(negedge clk);
        bus_wr = 1'b0; rxb_valid = 1'b0;
        rd_chk("R12 event priority", 12'h100, 1);

        // R8 stop receiver
        wr(12'h004, 1);
        check("R8 rx stopped", {31'b0, rxb_ready}, 0);
        rd_chk("R8 timeout event", 12'h10C, 1);
        rd_chk("R7 stopped no advance", 12'h304, 32'h5A);
        rd_chk("R7 stopped no advance", 12'h304, 32'h5A);
        push(8'h99);
        wr(12'h000, 1);
        rd_chk("R6 dropped while stopped", 12'h304, 32'h5A);

        // R5 transmit path
        wr(12'h308, 32'hA5);
        check("R5 not started", {31'b0, txb_valid}, 0);
        wr(12'h008, 1);
        wr(12'h308, 32'hA5);
        check("R5 valid", {23'b0, txb_valid, txb_data}, 32'h1A5);
        wr(12'h308, 32'h3C);
        check("R5 pending kept", {23'b0, txb_valid, txb_data}, 32'h1A5);
        rd_chk("R5 no event yet", 12'h104, 0);
        @(negedge clk); txb_ready = 1'b1;
        @(negedge clk); txb_ready = 1'b0;
        check("R5 sent", {31'b0, txb_valid}, 0);
        rd_chk("R5 tx event", 12'h104, 1);
        wr(12'h00C, 1);
        check("R8 rx still started", {31'b0, rxb_ready}, 1);
        wr(12'h308, 32'h3C);
        check("R8 tx stopped", {31'b0, txb_valid}, 0);
        wr(12'h00C, 0);

        // R9 / R10 break and error source
        @(negedge clk); line_break = 1'b1;
        @(negedge clk); line_break = 1'b0;
        rd_chk("R10 errsrc", 12'h280, 3);
        rd_chk("R10 error event", 12'h108, 1);
        wr(12'h280, 1);
        rd_chk("R9 w1c", 12'h280, 2);
        wr(12'h108, 0);
        rd_chk("R9 event clear", 12'h108, 0);
        wr(12'h108, 1);
        rd_chk("R9 event set", 12'h108, 1);
        wr(12'h314, 32'h0000_0007);
        rd_chk("R9 pin store", 12'h314, 7);

        finish_run();
    end
endmodule